// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits beside a two-bank synchronous DRAM command bus and watches what the controller drives on it. On each rising clock edge it samples chip select, the three strobes (row, column, write), clock enable and the address bus. It turns the sampled pins into a one-hot command strobe and follows the open or closed state of every bank. That includes scheduled auto-precharge, which starts one or two clocks after the column command, depending on the CAS latency input.

A command that does not fit the current bank state is still decoded, and an illegal flag is raised beside it. Such commands are a column access to a closed bank, or to a bank that is already counting down to auto-precharge, an activate to an open bank, and a refresh or mode-set while any bank is open. An illegal command never changes bank state.

The block has no data stream. Every pin is plain control or status, so there is no valid/ready handshake and no back-pressure. All outputs are registered and reflect the command sampled at the previous rising edge.

Top module: `sdc_tracker`

## Requirements
- R1: The command sampled with chip select low appears on `cmd_strobe` one clock later, as exactly one bit set. The bits are NOP=0, activate=1, read=2, write=3, precharge=4, burst stop=5, auto refresh=6, self refresh=7, mode set=8.
- R1: The encodings of {ras_n,cas_n,we_n} are 111 NOP, 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop, 001 refresh and 000 mode set. NOP and burst stop are always legal and leave bank state alone.
- R2: With chip select high, `cmd_strobe` is all zero and `illegal` is low one clock later, and no bank opens or closes. The exception is a running auto-precharge countdown, which continues.
- R3: A legal activate opens the bank given by `addr[11]` (0 = bank A, 1 = bank B) and stores `addr[10:0]` as that bank's row on `bank_row` (bank n at bits n*11 and up). An activate to an open bank is illegal.
- R4: A read or write to a closed bank, or to a bank with auto-precharge pending, is illegal. An illegal command leaves `bank_open` and `ap_pending` unchanged.
- R5: A precharge with `addr[10]` high closes both banks. With `addr[10]` low it closes only the bank given by `addr[11]`. A precharge clears any pending auto-precharge of the banks it closes, and a precharge of a closed bank is legal and has no effect.
- R6: A legal read or write with `addr[10]` high sets `ap_pending` for the bank given by `addr[11]`. That bank closes D clocks after the command's edge, with D=2 for `cas_lat`=3 and D=1 for `cas_lat`=1 or 2. Until then the bank stays open.
- R7: A refresh with `cke` low decodes as self refresh and with `cke` high as auto refresh. Refresh and mode set are illegal while any bank is open.
- R8: Reset clears all strobes, the illegal flag, open banks, pending auto-precharge and stored rows.
- R9: `cmd_bank` shows, one clock later, the `addr[11]` value sampled with the last command issued with chip select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low accepts a command |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable |
| cke | input | 1 | Clock enable, separates self refresh from auto refresh |
| addr | input | 12 | Address: [10:0] row, [10] precharge-all or auto-precharge, [11] bank |
| cas_lat | input | 2 | CAS latency, 1 to 3 |
| cmd_strobe | output | 9 | One-hot decoded command |
| cmd_bank | output | 1 | Bank of the last decoded command |
| bank_open | output | 2 | Open state per bank |
| ap_pending | output | 2 | Auto-precharge scheduled per bank |
| bank_row | output | 22 | Stored row per bank |
| illegal | output | 1 | Last command was illegal for the bank state |

## Verification
A wrong bank state becomes visible at the ports in one of two ways. `bank_open` shows it on the clock after the faulty edge. Otherwise it surfaces only when a later command is judged against it, as a spurious or missing `illegal` pulse one clock after that command. The sweep therefore starts from every open-bank pattern, applies every pin combination and checks strobe, flag and state on the very next clock. It then follows each auto-precharge clock by clock, so that a countdown one cycle off shows as `bank_open` falling on the wrong edge.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CMD_N   = 9;
  localparam int CI_NOP  = 0;
  localparam int CI_ACT  = 1;
  localparam int CI_RD   = 2;
  localparam int CI_WR   = 3;
  localparam int CI_PRE  = 4;
  localparam int CI_BST  = 5;
  localparam int CI_AREF = 6;
  localparam int CI_SREF = 7;
  localparam int CI_MRS  = 8;
  localparam int APC_W   = 2;
endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
  import sdc_pkg::*;
(
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             cke,
  output logic [CMD_N-1:0] strobe
);
  always_comb begin
    strobe = '0;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b111: strobe[CI_NOP] = 1'b1;
        3'b011: strobe[CI_ACT] = 1'b1;
        3'b101: strobe[CI_RD]  = 1'b1;
        3'b100: strobe[CI_WR]  = 1'b1;
        3'b010: strobe[CI_PRE] = 1'b1;
        3'b110: strobe[CI_BST] = 1'b1;
        3'b001: begin
          if (cke) strobe[CI_AREF] = 1'b1;
          else     strobe[CI_SREF] = 1'b1;
        end
        default: strobe[CI_MRS] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank
  import sdc_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_hit,
  input  logic             act_go,
  input  logic             ap_arm,
  input  logic [APC_W-1:0] ap_delay,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic             ap_pend,
  output logic [ROW_W-1:0] row_q
);
  logic [APC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      ap_pend <= 1'b0;
      cnt_q   <= '0;
      row_q   <= '0;
    end else if (pre_hit) begin
      is_open <= 1'b0;
      ap_pend <= 1'b0;
      cnt_q   <= '0;
    end else if (act_go) begin
      is_open <= 1'b1;
      row_q   <= row_in;
    end else if (ap_arm) begin
      ap_pend <= 1'b1;
      cnt_q   <= ap_delay;
    end else if (ap_pend) begin
      if (cnt_q <= APC_W'(1)) begin
        is_open <= 1'b0;
        ap_pend <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q - APC_W'(1);
      end
    end
  end
endmodule

// File: rtl/sdc_tracker.sv
module sdc_tracker
  import sdc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 11,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = ROW_W + BANK_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic                       cke,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [1:0]                 cas_lat,
  output logic [CMD_N-1:0]           cmd_strobe,
  output logic [BANK_W-1:0]          cmd_bank,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS-1:0]       ap_pending,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row,
  output logic                       illegal
);
  logic [CMD_N-1:0]  dec;
  logic [BANK_W-1:0] sel;
  logic              tgt_open, tgt_pend, col_cmd, idle_cmd, ill;
  logic [APC_W-1:0]  ap_delay;

  sdc_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke), .strobe(dec)
  );

  assign sel      = addr[ROW_W +: BANK_W];
  assign tgt_open = bank_open[sel];
  assign tgt_pend = ap_pending[sel];
  assign col_cmd  = dec[CI_RD] | dec[CI_WR];
  assign idle_cmd = dec[CI_AREF] | dec[CI_SREF] | dec[CI_MRS];
  assign ap_delay = (cas_lat == 2'd3) ? APC_W'(2) : APC_W'(1);

  always_comb begin
    ill = 1'b0;
    if (dec[CI_ACT] && tgt_open)                ill = 1'b1;
    if (col_cmd && (!tgt_open || tgt_pend))     ill = 1'b1;
    if (idle_cmd && (|bank_open))               ill = 1'b1;
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit, pre_hit, act_go, ap_arm;
    assign hit     = (sel == BANK_W'(i));
    assign pre_hit = dec[CI_PRE] & (addr[AP_BIT] | hit);
    assign act_go  = dec[CI_ACT] & ~ill & hit;
    assign ap_arm  = col_cmd & addr[AP_BIT] & ~ill & hit;

    sdc_bank #(.ROW_W(ROW_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .pre_hit(pre_hit), .act_go(act_go), .ap_arm(ap_arm),
      .ap_delay(ap_delay), .row_in(addr[ROW_W-1:0]),
      .is_open(bank_open[i]), .ap_pend(ap_pending[i]),
      .row_q(bank_row[i*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_strobe <= '0;
      cmd_bank   <= '0;
      illegal    <= 1'b0;
    end else begin
      cmd_strobe <= dec;
      illegal    <= ill;
      if (!cs_n) cmd_bank <= sel;
    end
  end
endmodule

// File: rtl/sdc_tracker_chk.sv
module sdc_tracker_chk
  import sdc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 11,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = ROW_W + BANK_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_n,
  input logic                       ras_n,
  input logic                       cas_n,
  input logic                       we_n,
  input logic                       cke,
  input logic [ADDR_W-1:0]          addr,
  input logic [1:0]                 cas_lat,
  input logic [CMD_N-1:0]           cmd_strobe,
  input logic [BANK_W-1:0]          cmd_bank,
  input logic [NUM_BANKS-1:0]       bank_open,
  input logic [NUM_BANKS-1:0]       ap_pending,
  input logic [NUM_BANKS*ROW_W-1:0] bank_row,
  input logic                       illegal
);
  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_strobe));

  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cmd_strobe == '0 && !illegal));

  assert_deselect_no_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ((bank_open & ~$past(bank_open)) == '0));

  assert_illegal_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && $past(ap_pending) == '0) |-> $stable(bank_open));

  assert_pend_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_pending & ~bank_open) == '0);

  assert_pre_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && cas_n && !we_n && addr[AP_BIT]) |=> (bank_open == '0));

  assert_refresh_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_strobe[CI_AREF] || cmd_strobe[CI_SREF] || cmd_strobe[CI_MRS]) && !illegal)
      |-> ($past(bank_open) == '0));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_chk
    assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !ras_n && cas_n && we_n && addr[ROW_W +: BANK_W] == BANK_W'(i)
        && !ap_pending[i]) |=> bank_open[i]);
  end
endmodule

bind sdc_tracker sdc_tracker_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .AP_BIT(AP_BIT)
) u_chk (.*);

// File: tb/tb_sdc_tracker.sv
module tb_sdc_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [11:0] addr = '0;
  logic [1:0]  cas_lat = 2'd1;
  logic [8:0]  cmd_strobe;
  logic [0:0]  cmd_bank;
  logic [1:0]  bank_open, ap_pending;
  logic [21:0] bank_row;
  logic        illegal;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdc_tracker dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .addr(addr), .cas_lat(cas_lat),
    .cmd_strobe(cmd_strobe), .cmd_bank(cmd_bank), .bank_open(bank_open),
    .ap_pending(ap_pending), .bank_row(bank_row), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit cs, input logic [2:0] code, input bit ck,
                      input bit a10, input bit a11, input logic [9:0] low);
    cs_n = cs; {ras_n, cas_n, we_n} = code; cke = ck; addr = {a11, a10, low};
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b1, 3'b111, 1'b1, 1'b0, 1'b0, 10'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; cke = 1'b1; addr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int exp_idx(input logic [2:0] code, input bit ck);
    case (code)
      3'b111: return 0;
      3'b011: return 1;
      3'b101: return 2;
      3'b100: return 3;
      3'b010: return 4;
      3'b110: return 5;
      3'b001: return ck ? 6 : 7;
      default: return 8;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R8: reset state
    chk(cmd_strobe == 0, "R8", "strobe after reset", cmd_strobe, 0);
    chk(bank_open == 0 && ap_pending == 0, "R8", "banks after reset",
        {bank_open, ap_pending}, 0);
    chk(bank_row == 0 && !illegal, "R8", "row/illegal after reset", bank_row, 0);

    for (int cl = 1; cl <= 3; cl++) begin
      for (int cs = 0; cs < 2; cs++) begin
        for (int m = 0; m < 4; m++) begin
          for (int code = 0; code < 8; code++) begin
            for (int a10 = 0; a10 < 2; a10++) begin
              for (int a11 = 0; a11 < 2; a11++) begin
                for (int ck = 0; ck < 2; ck++) begin
                  int idx, b, d, newm, newp;
                  bit ill;
                  logic [9:0] low;
                  cas_lat = 2'(cl);
                  do_reset();
                  for (int s = 0; s < 2; s++)
                    if (m[s]) step(1'b0, 3'b011, 1'b1, 1'b0, s[0], 10'(100 + 3 * s));
                  for (int s = 0; s < 2; s++)
                    if (m[s]) chk(bank_row[s*11 +: 11] == 11'(100 + 3 * s), "R3",
                                  "setup row", bank_row[s*11 +: 11], 11'(100 + 3 * s));
                  low = 10'(code * 37 + m * 5 + a11 * 3 + 1);
                  step(cs[0], 3'(code), ck[0], a10[0], a11[0], low);
                  b = a11;
                  if (cs == 1) begin
                    chk(cmd_strobe == 0 && !illegal, "R2", "deselect strobe",
                        {illegal, cmd_strobe}, 0);
                    chk(bank_open == 2'(m), "R2", "deselect state", bank_open, m);
                  end else begin
                    idx = exp_idx(3'(code), ck[0]);
                    ill = (idx == 1 && m[b]) || ((idx == 2 || idx == 3) && !m[b])
                          || (idx >= 6 && m != 0);
                    newm = m; newp = 0;
                    if (!ill) begin
                      if (idx == 1) newm = m | (1 << b);
                      if (idx == 4) newm = a10 ? 0 : (m & ~(1 << b));
                      if ((idx == 2 || idx == 3) && a10) newp = 1 << b;
                    end
                    chk(cmd_strobe == 9'(1 << idx), "R1", "strobe", cmd_strobe, 1 << idx);
                    chk(cmd_bank == 1'(b), "R9", "cmd_bank", cmd_bank, b);
                    chk(illegal == ill, (idx >= 6) ? "R7" : (idx == 1 ? "R3" : "R4"),
                        "illegal", illegal, ill);
                    chk(bank_open == 2'(newm), (idx == 4) ? "R5" : "R4", "bank_open",
                        bank_open, newm);
                    chk(ap_pending == 2'(newp), "R6", "ap_pending", ap_pending, newp);
                    if (idx == 1 && !ill)
                      chk(bank_row[b*11 +: 11] == {a10[0], low}, "R3", "row latch",
                          bank_row[b*11 +: 11], {a10[0], low});
                    if (newp != 0) begin
                      d = (cl == 3) ? 2 : 1;
                      for (int t = 1; t <= d; t++) begin
                        idle();
                        if (t < d) begin
                          chk(ap_pending == 2'(newp) && bank_open == 2'(newm), "R6",
                              "ap still pending", {ap_pending, bank_open}, {newp[1:0], newm[1:0]});
                        end else begin
                          chk(ap_pending == 0, "R6", "ap cleared", ap_pending, 0);
                          chk(bank_open == 2'(newm & ~newp), "R6", "ap closed bank",
                              bank_open, newm & ~newp);
                        end
                      end
                    end
                  end
                end
              end
            end
          end
        end
      end
    end

    // R4: column access during pending auto-precharge; R5: precharge clears it
    for (int cl = 1; cl <= 3; cl++) begin
      cas_lat = 2'(cl);
      do_reset();
      step(1'b0, 3'b011, 1'b1, 1'b0, 1'b0, 10'd7);
      step(1'b0, 3'b101, 1'b1, 1'b1, 1'b0, 10'd1);
      step(1'b0, 3'b100, 1'b1, 1'b0, 1'b0, 10'd2);
      chk(illegal == 1'b1, "R4", "access while ap pending", illegal, 1);
      chk(bank_open == ((cl == 3) ? 2'b01 : 2'b00), "R4", "ap pending bank state",
          bank_open, (cl == 3) ? 1 : 0);
      idle();
      chk(bank_open == 0 && ap_pending == 0, "R6", "closed after pending", bank_open, 0);

      do_reset();
      step(1'b0, 3'b011, 1'b1, 1'b0, 1'b1, 10'd9);
      step(1'b0, 3'b100, 1'b1, 1'b1, 1'b1, 10'd3);
      step(1'b0, 3'b010, 1'b1, 1'b0, 1'b1, 10'd0);
      chk(bank_open == 0 && ap_pending == 0 && !illegal, "R5", "precharge clears ap",
          {illegal, bank_open, ap_pending}, 0);
      idle();
      chk(bank_open == 0 && ap_pending == 0, "R5", "stays closed", bank_open, 0);

      do_reset();
      step(1'b0, 3'b011, 1'b1, 1'b0, 1'b0, 10'd5);
      step(1'b0, 3'b101, 1'b1, 1'b1, 1'b0, 10'd1);
      rst_n = 1'b0;
      @(negedge clk);
      chk(bank_open == 0 && ap_pending == 0, "R8", "reset clears ap",
          {bank_open, ap_pending}, 0);
      rst_n = 1'b1;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule